// File: doc/BRIEF.md
# Plug-Detect and Receiver-Sense Debounce Filter

This block cleans up two slowly changing, asynchronous detect lines: a hot-plug detect input and a receiver-sense input. Each line is brought into the clock domain through a two-flop synchronizer. It then passes through two filter stages. The first stage is a short glitch rejector counted in clock cycles. The second stage is a stability qualifier whose threshold is counted in units of 1024 cycles. The qualified level of each line is available as a status output. Each line also drives a one-cycle rise event and a one-cycle fall event, meant to feed an interrupt controller.

Each line has its own glitch setting (4 bits) and its own stability setting (12 bits), and both are plain inputs. A glitch setting G removes any excursion that lasts G cycles or fewer. A stability setting S refuses any new level that holds for S×1024 cycles or fewer. With both settings at zero the filter only adds the synchronizer and pipeline delay.

Top module: `detect_debounce`

## Requirements
- R1: After reset, both filtered levels and all four event outputs are 0 while the raw inputs are held low.
- R2: On either line, a raw excursion that lasts G cycles or fewer, where G is that line's glitch setting, leaves the filtered level and that line's events unchanged.
- R3: On either line, a raw excursion that lasts S×1024 cycles or fewer, where S is that line's stability setting, is not accepted. If the line returns to the old level before that, the qualification restarts.
- R4: A raw step that is held long enough appears on the filtered level exactly G + S×1024 + 4 clock edges after the edge that first samples it.
- R5: With both settings at zero, a raw step reaches the filtered level after exactly 4 edges.
- R6: The rise event is high for exactly one cycle: the first cycle in which the filtered level reads 1 after reading 0.
- R7: The fall event is high for exactly one cycle: the first cycle in which the filtered level reads 0 after reading 1.
- R8: The two lines are independent. Activity on one line never moves the other line's level or events, and each line uses only its own settings.
- R9: A raw pulse of width W, with W greater than both G and S×1024, gives exactly one rise event and one fall event, and the level ends back at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| plug_raw | input | 1 | Asynchronous hot-plug detect line |
| sense_raw | input | 1 | Asynchronous receiver-sense line |
| plug_glitch | input | 4 | Glitch setting G for the plug line |
| plug_hold | input | 12 | Stability setting S for the plug line, in units of 1024 cycles |
| sense_glitch | input | 4 | Glitch setting G for the sense line |
| sense_hold | input | 12 | Stability setting S for the sense line, in units of 1024 cycles |
| plug_level | output | 1 | Filtered plug level |
| sense_level | output | 1 | Filtered sense level |
| plug_rise | output | 1 | One-cycle event on a plug rise |
| plug_fall | output | 1 | One-cycle event on a plug fall |
| sense_rise | output | 1 | One-cycle event on a sense rise |
| sense_fall | output | 1 | One-cycle event on a sense fall |

## Verification
A raw change first shows up in the first synchronizer flop. It reaches the glitch stage's input after two edges and leaves that stage G+1 edges later. The qualified level and its event then follow S×1024+1 edges after that, for G + S×1024 + 4 edges in total. The bench drives inputs and samples outputs on falling edges. It looks at the level exactly one cycle before and at that total count, and checks that the event is present there and gone one cycle later. Pulse trials count events over a window longer than the pulse plus the full latency. They compare those counts against the rule that a pulse passes only if its width exceeds both G and S×1024.

// File: rtl/detect_debounce_pkg.sv
package detect_debounce_pkg;
  localparam int GLITCH_W   = 4;
  localparam int HOLD_W     = 12;
  localparam int SCALE_LOG2 = 10;
  localparam int NUM_LINES  = 2;
  localparam int QCNT_W     = HOLD_W + SCALE_LOG2;
endpackage

// File: rtl/dd_sync2.sv
module dd_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= din;
      stage2_q <= stage1_q;
    end
  end

  assign dout = stage2_q;
endmodule

// File: rtl/dd_glitch.sv
module dd_glitch #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_in,
  input  logic [CNT_W-1:0] limit,
  output logic             clean
);
  logic             level_q, level_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             differ;
  logic             accept;

  always_comb begin
    differ  = (sync_in != level_q);
    accept  = differ && (cnt_q >= limit);
    level_d = level_q;
    cnt_d   = cnt_q;
    if (!differ) begin
      cnt_d = '0;
    end else if (accept) begin
      level_d = sync_in;
      cnt_d   = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      level_q <= level_d;
      cnt_q   <= cnt_d;
    end
  end

  assign clean = level_q;

  AST_GLITCH_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (clean != $past(clean)) |-> ($past(sync_in) == clean)); // R2
endmodule

// File: rtl/dd_qualify.sv
module dd_qualify #(
  parameter int HOLD_W     = 12,
  parameter int SCALE_LOG2 = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clean_in,
  input  logic [HOLD_W-1:0] hold,
  output logic              level,
  output logic              rise,
  output logic              fall
);
  localparam int CW = HOLD_W + SCALE_LOG2;

  logic          level_q, level_d;
  logic          rise_q, rise_d;
  logic          fall_q, fall_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] span;
  logic          differ;
  logic          accept;

  assign span = {hold, {SCALE_LOG2{1'b0}}};

  always_comb begin
    differ  = (clean_in != level_q);
    accept  = differ && (cnt_q >= span);
    level_d = level_q;
    cnt_d   = cnt_q;
    rise_d  = 1'b0;
    fall_d  = 1'b0;
    if (!differ) begin
      cnt_d = '0;
    end else if (accept) begin
      level_d = clean_in;
      cnt_d   = '0;
      rise_d  = clean_in;
      fall_d  = !clean_in;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= 1'b0;
      cnt_q   <= '0;
      rise_q  <= 1'b0;
      fall_q  <= 1'b0;
    end else begin
      level_q <= level_d;
      cnt_q   <= cnt_d;
      rise_q  <= rise_d;
      fall_q  <= fall_d;
    end
  end

  assign level = level_q;
  assign rise  = rise_q;
  assign fall  = fall_q;

  AST_LEVEL_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    (level != $past(level)) |-> ($past(clean_in) == level)); // R3
  AST_RISE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    rise |-> (level && !$past(level))); // R6
  AST_FALL_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    fall |-> (!level && $past(level))); // R7
  AST_EVENT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise && fall)); // R6
  AST_RISE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise); // R6
endmodule

// File: rtl/detect_debounce.sv
module detect_debounce
  import detect_debounce_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                plug_raw,
  input  logic                sense_raw,
  input  logic [GLITCH_W-1:0] plug_glitch,
  input  logic [HOLD_W-1:0]   plug_hold,
  input  logic [GLITCH_W-1:0] sense_glitch,
  input  logic [HOLD_W-1:0]   sense_hold,
  output logic                plug_level,
  output logic                sense_level,
  output logic                plug_rise,
  output logic                plug_fall,
  output logic                sense_rise,
  output logic                sense_fall
);
  logic rst_meta_q, rst_sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic [NUM_LINES-1:0]                raw_v, sync_v, clean_v, lvl_v, rise_v, fall_v;
  logic [NUM_LINES-1:0][GLITCH_W-1:0]  glitch_v;
  logic [NUM_LINES-1:0][HOLD_W-1:0]    hold_v;

  assign raw_v    = {sense_raw, plug_raw};
  assign glitch_v = {sense_glitch, plug_glitch};
  assign hold_v   = {sense_hold, plug_hold};

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    dd_sync2 u_sync (
      .clk   (clk),
      .rst_n (rst_sync_q),
      .din   (raw_v[i]),
      .dout  (sync_v[i])
    );
    dd_glitch #(.CNT_W(GLITCH_W)) u_glitch (
      .clk     (clk),
      .rst_n   (rst_sync_q),
      .sync_in (sync_v[i]),
      .limit   (glitch_v[i]),
      .clean   (clean_v[i])
    );
    dd_qualify #(.HOLD_W(HOLD_W), .SCALE_LOG2(SCALE_LOG2)) u_qual (
      .clk      (clk),
      .rst_n    (rst_sync_q),
      .clean_in (clean_v[i]),
      .hold     (hold_v[i]),
      .level    (lvl_v[i]),
      .rise     (rise_v[i]),
      .fall     (fall_v[i])
    );
  end

  assign plug_level  = lvl_v[0];
  assign sense_level = lvl_v[1];
  assign plug_rise   = rise_v[0];
  assign plug_fall   = fall_v[0];
  assign sense_rise  = rise_v[1];
  assign sense_fall  = fall_v[1];

  AST_NO_RESET_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_sync_q |-> !(plug_rise || sense_rise || plug_fall || sense_fall)); // R1
endmodule

// File: tb/detect_debounce_test.sv
module detect_debounce_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        plug_raw = 1'b0, sense_raw = 1'b0;
  logic [3:0]  plug_glitch = '0, sense_glitch = '0;
  logic [11:0] plug_hold = '0, sense_hold = '0;
  logic        plug_level, sense_level, plug_rise, plug_fall, sense_rise, sense_fall;

  detect_debounce uut (
    .clk(clk), .rst_n(rst_n), .plug_raw(plug_raw), .sense_raw(sense_raw),
    .plug_glitch(plug_glitch), .plug_hold(plug_hold),
    .sense_glitch(sense_glitch), .sense_hold(sense_hold),
    .plug_level(plug_level), .sense_level(sense_level),
    .plug_rise(plug_rise), .plug_fall(plug_fall),
    .sense_rise(sense_rise), .sense_fall(sense_fall)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0, cycles = 0;
  int p_rise_n = 0, p_fall_n = 0, s_rise_n = 0, s_fall_n = 0;
  bit done = 0;

  always @(negedge clk) begin
    cycles++;
    if (plug_rise)  p_rise_n++;
    if (plug_fall)  p_fall_n++;
    if (sense_rise) s_rise_n++;
    if (sense_fall) s_fall_n++;
    if (cycles > WATCHDOG && !done) begin
      done = 1;
      fails++; checks++;
      $display("FAIL watchdog: actual %0d cycles expected < %0d", cycles, WATCHDOG);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int due(input int g, input int s);
    return g + s * 1024 + 4;
  endfunction

  function automatic bit passes(input int w, input int g, input int s);
    return (w > g) && (w > s * 1024);
  endfunction

  task automatic clear_counts();
    p_rise_n = 0; p_fall_n = 0; s_rise_n = 0; s_fall_n = 0;
  endtask

  // Pulse trial on one line (0 = plug, 1 = sense); the other line stays low.
  task automatic pulse_trial(input int line, input int g, input int s, input int w);
    int wait_n;
    bit exp_pass;
    @(negedge clk);
    if (line == 0) begin plug_glitch = 4'(g); plug_hold = 12'(s); end
    else begin sense_glitch = 4'(g); sense_hold = 12'(s); end
    repeat (3) @(negedge clk);
    clear_counts();
    if (line == 0) plug_raw = 1'b1; else sense_raw = 1'b1;
    repeat (w) @(negedge clk);
    if (line == 0) plug_raw = 1'b0; else sense_raw = 1'b0;
    wait_n = due(g, s) + w + 8;
    repeat (wait_n) @(negedge clk);
    exp_pass = passes(w, g, s);
    if (line == 0) begin
      check(p_rise_n == int'(exp_pass), exp_pass ? "R9 plug rise count" : "R2/R3 plug rise count", p_rise_n, int'(exp_pass));
      check(p_fall_n == int'(exp_pass), "R9 plug fall count", p_fall_n, int'(exp_pass));
      check(plug_level == 1'b0, "R9 plug final level", plug_level, 0);
      check(s_rise_n + s_fall_n == 0, "R8 sense untouched", s_rise_n + s_fall_n, 0);
    end else begin
      check(s_rise_n == int'(exp_pass), exp_pass ? "R9 sense rise count" : "R2/R3 sense rise count", s_rise_n, int'(exp_pass));
      check(s_fall_n == int'(exp_pass), "R9 sense fall count", s_fall_n, int'(exp_pass));
      check(sense_level == 1'b0, "R9 sense final level", sense_level, 0);
      check(p_rise_n + p_fall_n == 0, "R8 plug untouched", p_rise_n + p_fall_n, 0);
    end
  endtask

  initial begin
    int d;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    check(plug_level == 0 && sense_level == 0, "R1 levels in reset", plug_level + sense_level, 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check({plug_rise, plug_fall, sense_rise, sense_fall} == 4'b0, "R1 events after reset",
          {plug_rise, plug_fall, sense_rise, sense_fall}, 0);
    check(plug_level == 0 && sense_level == 0, "R1 levels after reset", plug_level + sense_level, 0);

    // R5 zero settings latency on sense line
    d = due(0, 0);
    sense_raw = 1'b1;
    repeat (d - 1) @(negedge clk);
    check(sense_level == 0, "R5 level one cycle early", sense_level, 0);
    @(negedge clk);
    check(sense_level == 1, "R5 level on time", sense_level, 1);
    check(sense_rise == 1, "R6 sense rise on time", sense_rise, 1);
    check(plug_level == 0 && plug_rise == 0, "R8 plug idle", plug_level, 0);
    @(negedge clk);
    check(sense_rise == 0, "R6 sense rise one cycle", sense_rise, 0);
    sense_raw = 1'b0;
    repeat (d) @(negedge clk);
    check(sense_fall == 1 && sense_level == 0, "R7 sense fall on time", sense_fall, 1);
    @(negedge clk);
    check(sense_fall == 0, "R7 sense fall one cycle", sense_fall, 0);

    // R4 latency with G=3, S=1 on plug line; sense gets different settings (R8)
    plug_glitch = 4'd3; plug_hold = 12'd1;
    sense_glitch = 4'd9; sense_hold = 12'd0;
    repeat (3) @(negedge clk);
    d = due(3, 1);
    plug_raw = 1'b1;
    repeat (d - 1) @(negedge clk);
    check(plug_level == 0, "R4 plug one cycle early", plug_level, 0);
    check(plug_rise == 0, "R6 no early rise", plug_rise, 0);
    @(negedge clk);
    check(plug_level == 1, "R4 plug on time", plug_level, 1);
    check(plug_rise == 1, "R6 plug rise on time", plug_rise, 1);
    @(negedge clk);
    check(plug_rise == 0, "R6 plug rise one cycle", plug_rise, 0);
    plug_raw = 1'b0;
    repeat (d - 1) @(negedge clk);
    check(plug_level == 1 && plug_fall == 0, "R4 plug fall one cycle early", plug_level, 1);
    @(negedge clk);
    check(plug_level == 0 && plug_fall == 1, "R7 plug fall on time", plug_fall, 1);
    @(negedge clk);
    check(plug_fall == 0, "R7 plug fall one cycle", plug_fall, 0);

    // R3 restart: dip back before qualification ends, then a long hold
    plug_glitch = 4'd0; plug_hold = 12'd1;
    repeat (3) @(negedge clk);
    clear_counts();
    plug_raw = 1'b1; repeat (700) @(negedge clk);
    plug_raw = 1'b0; repeat (3) @(negedge clk);
    plug_raw = 1'b1; repeat (700) @(negedge clk);
    check(plug_level == 0 && p_rise_n == 0, "R3 restart blocks accept", p_rise_n, 0);
    repeat (400) @(negedge clk);
    check(plug_level == 1 && p_rise_n == 1, "R3 accepts after full hold", p_rise_n, 1);
    plug_raw = 1'b0; repeat (1100) @(negedge clk);
    check(plug_level == 0, "R3 back low", plug_level, 0);

    // Directed glitch boundaries (R2)
    pulse_trial(1, 5, 0, 5);
    pulse_trial(1, 5, 0, 6);
    pulse_trial(0, 15, 0, 15);
    pulse_trial(0, 15, 0, 16);
    pulse_trial(0, 0, 1, 1024); // R3 boundary
    pulse_trial(0, 0, 1, 1025);

    // Constrained random trials
    for (int t = 0; t < 30; t++) begin
      int line, g, s, w, pick;
      line = $urandom_range(0, 1);
      g = $urandom_range(0, 15);
      s = ($urandom_range(0, 5) == 0) ? 1 : 0;
      pick = $urandom_range(0, 3);
      case (pick)
        0: w = g;
        1: w = g + 1;
        2: w = (s == 1) ? 1024 + $urandom_range(0, 1) : $urandom_range(1, 3);
        default: w = $urandom_range(1, 40);
      endcase
      if (w < 1) w = 1;
      pulse_trial(line, g, s, w);
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule